// File: doc/BRIEF.md
# Internal Reconfiguration Command Sequencer

This block lets user logic force the device to reload its configuration from flash. A rising edge on a trigger input starts a fixed burst of 32-bit configuration words toward the device's internal configuration access port, one word per clock. The burst has four parts. First come a preamble of dummy, sync and no-op words. Then comes an optional write of the warm-boot start address. Then the reprogram command is written to the command register. The burst ends with a run of no-op words.

A select flag chooses the image to load. With the flag low, the address write is left out and the device reloads its default image. With the flag high, the alternate flash address is written first, so that the restart fetches the image stored at that address. The select flag and the address are captured when the burst starts. The words leave the block without any bit reordering, and a separate wrapper stage applies any bit swap that the access port needs.

Top module: `cfg_reload_seq`

## Requirements
- R1: After reset, `cfg_ce_n` and `cfg_wr_n` are 1, `busy` is 0 and `cfg_data` is 0x00000000.
- R2: A 0-to-1 change of `trig` seen at a clock edge while idle starts a burst. `busy` is 1 and the first word is on `cfg_data` right after that same edge.
- R3: Every burst opens with the words 0xFFFFFFFF, 0xAA995566 and 0x20000000, in that order.
- R4: With `sel` = 0, the preamble is followed by 0x30008001 (a write to command register 0x04), then 0x0000000F (the reprogram code), then `TRAIL_NOPS` words of 0x20000000. The burst is 5 + `TRAIL_NOPS` words long.
- R5: With `sel` = 1, the preamble is followed by 0x30020001 (a write to boot-address register 0x10), then the captured alternate address, then the same command words and trailer as in R4. The burst is 7 + `TRAIL_NOPS` words long.
- R6: A register-write header has bits [31:29] = 001, bits [28:27] = 10, the register address in bits [17:13] and a word count of 1 in bits [10:0]. All other bits are 0.
- R7: `cfg_ce_n` and `cfg_wr_n` are low exactly in the cycles where `busy` is 1. A new word appears in each of those cycles. `cfg_data` is 0 whenever `busy` is 0.
- R8: While `busy` is 1, trigger edges and changes of `sel` or `alt_addr` do not change the burst in progress. A `trig` level that is still held high when the burst ends does not start a new burst.
- R9: The alternate address appears on `cfg_data` with every bit in its original position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Reload request; its rising edge starts a burst |
| sel | input | 1 | 1 = load the alternate image, 0 = reload the default image |
| alt_addr | input | 32 | Flash address of the alternate image |
| cfg_data | output | 32 | Configuration word sent to the access port |
| cfg_ce_n | output | 1 | Access port enable, active low |
| cfg_wr_n | output | 1 | Write select, active low |
| busy | output | 1 | A burst is in progress |

## Verification
The checker assumes that `trig` is held low for at least two cycles after reset is released. Under that assumption, the first burst cannot start while the reset history is still being examined. It also assumes that reset is held for several clocks, so that every history term it reads is a known value. The stimulus drives inputs only on falling edges and keeps `trig` low through reset. It deliberately toggles `trig`, `sel` and `alt_addr` during bursts and holds `trig` high across the end of a burst, so that R8 is exercised from both sides.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;
   localparam int WORD_W = 32;

   localparam logic [WORD_W-1:0] W_DUMMY  = 32'hFFFF_FFFF;
   localparam logic [WORD_W-1:0] W_SYNC   = 32'hAA99_5566;
   localparam logic [WORD_W-1:0] W_NOOP   = 32'h2000_0000;

   localparam logic [4:0]  REG_CMD    = 5'h04;
   localparam logic [4:0]  REG_BOOTAD = 5'h10;
   localparam logic [WORD_W-1:0] CODE_REPROG = 32'h0000_000F;

   // logical step numbers of the full (alternate) sequence
   localparam int STEP_BOOT_HDR = 3;
   localparam int STEP_BOOT_DAT = 4;
   localparam int STEP_CMD_HDR  = 5;
   localparam int STEP_CMD_DAT  = 6;
   localparam int PREAMBLE_LEN  = 3;
   localparam int BOOT_LEN      = 2;
   localparam int CMD_LEN       = 2;

   function automatic logic [WORD_W-1:0] wr_hdr(input logic [4:0] regad);
      logic [WORD_W-1:0] h;
      h          = '0;
      h[31:29]   = 3'b001;
      h[28:27]   = 2'b10;
      h[17:13]   = regad;
      h[10:0]    = 11'd1;
      return h;
   endfunction
endpackage

// File: rtl/cfg_trig_edge.sv
module cfg_trig_edge #(
   parameter bit PULSE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;
   logic rise;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

   generate
      if (PULSE_REG) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (rst) pulse_q <= 1'b0;
            else     pulse_q <= rise;
         end
         assign pulse = pulse_q;
      end else begin : g_comb
         assign pulse = rise;
      end
   endgenerate
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
   import cfg_reload_pkg::*;
#(
   parameter int TRAIL_NOPS = 2,
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              alt_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              active,
   output logic [IDX_W-1:0]  idx,
   output logic              alt_q,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int LEN_PLAIN = PREAMBLE_LEN + CMD_LEN + TRAIL_NOPS;
   localparam int LEN_ALT   = LEN_PLAIN + BOOT_LEN;
   localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(LEN_PLAIN - 1);
   localparam logic [IDX_W-1:0] LAST_ALT   = IDX_W'(LEN_ALT - 1);

   generate
      if ((1 << IDX_W) < LEN_ALT) begin : g_bad_idx
         $error("cfg_seq_ctrl: IDX_W too narrow for the sequence length");
      end
   endgenerate

   logic last;
   assign last = alt_q ? (idx == LAST_ALT) : (idx == LAST_PLAIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         idx    <= '0;
         alt_q  <= 1'b0;
         addr_q <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            idx    <= '0;
            alt_q  <= alt_in;
            addr_q <= addr_in;
         end
      end else if (last) begin
         active <= 1'b0;
         idx    <= '0;
      end else begin
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/cfg_word_gen.sv
module cfg_word_gen
   import cfg_reload_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              alt,
   input  logic [WORD_W-1:0] addr,
   output logic [WORD_W-1:0] word
);
   localparam logic [IDX_W:0] SKIP = (IDX_W+1)'(BOOT_LEN);
   localparam logic [IDX_W:0] PRE  = (IDX_W+1)'(PREAMBLE_LEN);

   logic [IDX_W:0] step;

   always_comb begin
      step = {1'b0, idx};
      if (!alt && step >= PRE) step = step + SKIP;
   end

   always_comb begin
      case (step)
         (IDX_W+1)'(0):             word = W_DUMMY;
         (IDX_W+1)'(1):             word = W_SYNC;
         (IDX_W+1)'(2):             word = W_NOOP;
         (IDX_W+1)'(STEP_BOOT_HDR): word = wr_hdr(REG_BOOTAD);
         (IDX_W+1)'(STEP_BOOT_DAT): word = addr;
         (IDX_W+1)'(STEP_CMD_HDR):  word = wr_hdr(REG_CMD);
         (IDX_W+1)'(STEP_CMD_DAT):  word = CODE_REPROG;
         default:                   word = W_NOOP;
      endcase
   end
endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq
   import cfg_reload_pkg::*;
#(
   parameter int TRAIL_NOPS = 2,
   parameter bit IDLE_ZERO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic              sel,
   input  logic [31:0]       alt_addr,
   output logic [31:0]       cfg_data,
   output logic              cfg_ce_n,
   output logic              cfg_wr_n,
   output logic              busy
);
   localparam int MAX_LEN = PREAMBLE_LEN + BOOT_LEN + CMD_LEN + TRAIL_NOPS;
   localparam int IDX_W   = $clog2(MAX_LEN);

   generate
      if (TRAIL_NOPS < 1) begin : g_bad_trail
         $error("cfg_reload_seq: TRAIL_NOPS must be at least 1");
      end
   endgenerate

   logic              start;
   logic              active;
   logic [IDX_W-1:0]  idx;
   logic              alt_q;
   logic [WORD_W-1:0] addr_q;
   logic [WORD_W-1:0] word;

   cfg_trig_edge #(.PULSE_REG(1'b0)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .lvl   (trig),
      .pulse (start)
   );

   cfg_seq_ctrl #(
      .TRAIL_NOPS (TRAIL_NOPS),
      .ADDR_W     (WORD_W),
      .IDX_W      (IDX_W)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .alt_in  (sel),
      .addr_in (alt_addr),
      .active  (active),
      .idx     (idx),
      .alt_q   (alt_q),
      .addr_q  (addr_q)
   );

   cfg_word_gen #(.IDX_W(IDX_W)) u_gen (
      .idx  (idx),
      .alt  (alt_q),
      .addr (addr_q),
      .word (word)
   );

   generate
      if (IDLE_ZERO) begin : g_gate
         assign cfg_data = active ? word : '0;
      end else begin : g_pass
         assign cfg_data = word;
      end
   endgenerate

   assign cfg_ce_n = ~active;
   assign cfg_wr_n = ~active;
   assign busy     = active;
endmodule

// File: rtl/cfg_reload_seq_chk.sv
module cfg_reload_seq_chk #(
   parameter int TRAIL_NOPS = 2
) (
   input logic        clk,
   input logic        rst,
   input logic [31:0] cfg_data,
   input logic        cfg_ce_n,
   input logic        cfg_wr_n,
   input logic        busy
);
   localparam int MAX_LEN = 7 + TRAIL_NOPS;
   int run_len;

   always_ff @(posedge clk) begin
      if (rst || !busy) run_len <= 0;
      else              run_len <= run_len + 1;
   end

   // R7
   ce_wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_ce_n == cfg_wr_n);
   // R7
   ce_busy_chk: assert property (@(posedge clk) disable iff (rst)
      busy == !cfg_ce_n);
   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> cfg_data == 32'h0);
   // R3
   first_dummy_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> cfg_data == 32'hFFFF_FFFF);
   // R3
   second_sync_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && !$past(busy, 2)) |-> cfg_data == 32'hAA99_5566);
   // R4
   last_noop_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(cfg_data) == 32'h2000_0000);
   // R5
   len_bound_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> run_len < MAX_LEN);
endmodule

bind cfg_reload_seq cfg_reload_seq_chk #(.TRAIL_NOPS(TRAIL_NOPS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cfg_data (cfg_data),
   .cfg_ce_n (cfg_ce_n),
   .cfg_wr_n (cfg_wr_n),
   .busy     (busy)
);

// File: tb/cfg_reload_seq_tb.sv
module cfg_reload_seq_tb;
   localparam int TRAIL = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        trig = 1'b0;
   logic        sel = 1'b0;
   logic [31:0] alt_addr = '0;
   logic [31:0] cfg_data;
   logic        cfg_ce_n, cfg_wr_n, busy;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [31:0] exp_q[$];
   logic [31:0] got_q[$];
   logic        m_prev = 1'b0;

   always #10 clk = ~clk;

   cfg_reload_seq #(.TRAIL_NOPS(TRAIL)) u_dut (
      .clk(clk), .rst(rst), .trig(trig), .sel(sel), .alt_addr(alt_addr),
      .cfg_data(cfg_data), .cfg_ce_n(cfg_ce_n), .cfg_wr_n(cfg_wr_n), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      if (rst) begin
         exp_q.delete();
         m_prev = 1'b0;
      end else begin
         if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
         end else if (trig && !m_prev) begin
            exp_q.push_back(32'hFFFF_FFFF);
            exp_q.push_back(32'hAA99_5566);
            exp_q.push_back(32'h2000_0000);
            if (sel) begin
               exp_q.push_back(32'h3002_0001);
               exp_q.push_back(alt_addr);
            end
            exp_q.push_back(32'h3000_8001);
            exp_q.push_back(32'h0000_000F);
            for (int i = 0; i < TRAIL; i++) exp_q.push_back(32'h2000_0000);
         end
         m_prev = trig;
      end
   end

   // per-cycle comparison and capture
   always @(negedge clk) begin
      if (!rst) begin
         logic        eb;
         logic [31:0] ed;
         eb = exp_q.size() > 0;
         ed = eb ? exp_q[0] : 32'h0;
         chk(busy == eb, "R7 busy", {31'b0, busy}, {31'b0, eb});
         chk(cfg_ce_n == !eb && cfg_wr_n == !eb, "R7 enables",
             {30'b0, cfg_ce_n, cfg_wr_n}, {30'b0, !eb, !eb});
         chk(cfg_data == ed, "R4 word", cfg_data, ed);
         if (busy) got_q.push_back(cfg_data);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic fire(input logic s, input logic [31:0] a);
      @(negedge clk);
      sel = s; alt_addr = a; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      chk(busy == 0 && cfg_ce_n && cfg_wr_n && cfg_data == 0, "R1 reset",
          cfg_data, 32'h0);
      repeat (2) @(negedge clk);

      // R2 start timing, R3/R4 default reload
      got_q.delete();
      fire(1'b0, 32'h1234_5678);
      chk(busy == 1'b1, "R2 busy after edge", {31'b0, busy}, 32'h1);
      chk(cfg_data == 32'hFFFF_FFFF, "R2 first word", cfg_data, 32'hFFFF_FFFF);
      wait_idle();
      chk(got_q.size() == 5 + TRAIL, "R4 length", got_q.size(), 5 + TRAIL);
      chk(got_q[0] == 32'hFFFF_FFFF && got_q[1] == 32'hAA99_5566 &&
          got_q[2] == 32'h2000_0000, "R3 preamble", got_q[1], 32'hAA99_5566);
      chk(got_q[3] == 32'h3000_8001, "R6 command header", got_q[3], 32'h3000_8001);
      chk(got_q[4] == 32'h0000_000F, "R4 reprogram code", got_q[4], 32'hF);
      chk(got_q[5 + TRAIL - 1] == 32'h2000_0000, "R4 trailer", got_q[5 + TRAIL - 1],
          32'h2000_0000);

      // R5 alternate image, R9 bit order
      got_q.delete();
      fire(1'b1, 32'h00A5_3C01);
      wait_idle();
      chk(got_q.size() == 7 + TRAIL, "R5 length", got_q.size(), 7 + TRAIL);
      chk(got_q[3] == 32'h3002_0001, "R6 boot header", got_q[3], 32'h3002_0001);
      chk(got_q[4] == 32'h00A5_3C01, "R9 address", got_q[4], 32'h00A5_3C01);
      chk(got_q[5] == 32'h3000_8001, "R5 command after address", got_q[5],
          32'h3000_8001);

      got_q.delete();
      fire(1'b1, 32'h8000_0001);
      wait_idle();
      chk(got_q[4] == 32'h8000_0001, "R9 edge bits", got_q[4], 32'h8000_0001);

      // R8 triggers and input changes during a burst are ignored
      got_q.delete();
      fire(1'b0, 32'h0);
      @(negedge clk);
      sel = 1'b1; alt_addr = 32'hDEAD_BEEF; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      trig = 1'b1;            // held high across the end of the burst
      wait_idle();
      chk(got_q.size() == 5 + TRAIL, "R8 burst unchanged", got_q.size(), 5 + TRAIL);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R8 held level no restart", {31'b0, busy}, 32'h0);
      trig = 1'b0;
      repeat (2) @(negedge clk);

      // back-to-back: new edge right after idle works
      got_q.delete();
      fire(1'b1, 32'h5A5A_A5A5);
      wait_idle();
      chk(got_q.size() == 7 + TRAIL && got_q[4] == 32'h5A5A_A5A5, "R5 retrigger",
          got_q[4], 32'h5A5A_A5A5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule